// File: doc/BRIEF.md
# One-Wire ROM Search Triplet Unit

This block carries out one decision step of the binary ROM search on a one-wire bus. After a start request it runs two read slots: the first returns the identifier bit of all responding devices and the second returns its complement. It then picks a branch direction. If the two reads disagree, the direction follows the identifier bit. If both read 0, the caller's preferred direction is used. If both read 1, no device answered and no direction is written. In every other case the chosen direction goes back onto the bus in a third slot, as a write-1 or a write-0 slot.

The block does not time slots itself. It hands each slot to a separate bit slot generator over a request/acknowledge handshake. `slot_req_o` stays high until the generator pulses `slot_ack_i` for one cycle. A request with `slot_wbit_o` = 1 is a write-1 slot, which is also the read slot, and the generator returns the sampled bus level on `slot_rbit_i` in the same cycle as the acknowledge. A request with `slot_wbit_o` = 0 is a write-0 slot. `slot_req_o` may stay high across two back-to-back slots, and each acknowledge completes exactly one slot.

The controller has six states. IDLE goes to READ_ID on an accepted start. READ_ID goes to READ_CMP on the acknowledge of the first slot. READ_CMP goes to DECIDE on the acknowledge of the second slot. DECIDE goes to WRITE_DIR when a direction exists, and to FINISH when both bits read 1 (the restart case). WRITE_DIR goes to FINISH on the acknowledge of the third slot. FINISH returns to IDLE unconditionally after one cycle.

Top module: `ow_search_triplet`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `slot_req_o` are 0 and `result_o` is 3'b000.
- R2: The first slot of a step is a read slot (`slot_wbit_o` = 1) whose returned level is the identifier bit. The second slot is also a read slot, and its returned level is the complement bit.
- R3: `result_o` bit 0 holds the identifier bit, bit 1 holds the complement bit and bit 2 holds the direction taken.
- R4: When both reads return 1, `result_o` becomes 3'b011, only two slots are requested, and no direction slot is issued.
- R5: When both reads return 0, the direction is the preferred direction captured at start. The result is 4 when that direction is 1 and 0 when it is 0.
- R6: When exactly one read returns 1, the direction equals the identifier bit. The result is 5 when the identifier bit is 1 and 2 when it is 0.
- R7: The third slot carries the direction on `slot_wbit_o` (1 = write-1 slot, 0 = write-0 slot), and `slot_wbit_o` holds steady while a request waits for its acknowledge.
- R8: `done_o` is a single-cycle pulse. It is high in the cycle after the third slot's acknowledge, or two cycles after the second read's acknowledge in the restart case.
- R9: `busy_o` rises in the cycle after an accepted start and stays high up to and including the `done_o` cycle. A start that arrives while busy is ignored.
- R10: An acknowledge that arrives while no request is pending changes no output and starts no slot.
- R11: `result_o` changes only at the decision point of an operation and otherwise keeps its value, including between operations.
- R12: `slot_req_o` stays high until acknowledged. The preferred direction is sampled only at start, so later changes to it have no effect on the running step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start one search step (accepted only when not busy) |
| pref_dir_i | input | 1 | Direction to take when both reads return 0 |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | {direction, complement bit, identifier bit}; 3'b011 = restart |
| slot_req_o | output | 1 | Slot request to the bit slot generator |
| slot_wbit_o | output | 1 | Slot kind: 1 = write-1/read slot, 0 = write-0 slot |
| slot_ack_i | input | 1 | One-cycle slot completion from the generator |
| slot_rbit_i | input | 1 | Sampled bus level, valid with `slot_ack_i` |

## Verification
The bench drives all four read combinations and both preferred directions. A decision table with its cases swapped would report 2 where 5 is due, and a design that ignored the preferred input would return 0 instead of 4. The restart case is checked for its slot count, because a design that wrote a direction anyway would issue a third slot and hold `done_o` back. The bench also sends starts mid-step, changes the preferred input after start, and pulses an acknowledge while idle. A design that restarted, re-sampled or advanced in these cases would show extra slots, a wrong direction or a spurious `busy_o`. Generator latencies of one and several cycles check that back-to-back requests are counted per acknowledge and not per request edge.

// File: rtl/ow_triplet_pkg.sv
package ow_triplet_pkg;

    // Width of the step result: {direction, complement, identifier}
    localparam int unsigned RES_W = 3;

    // Bit positions inside the result word
    localparam int unsigned RES_ID  = 0;
    localparam int unsigned RES_CMP = 1;
    localparam int unsigned RES_DIR = 2;

    // Result reported when neither a 0 nor a 1 answer was seen
    localparam logic [RES_W-1:0] RES_RESTART = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_ID   = 3'd1,
        ST_READ_CMP  = 3'd2,
        ST_DECIDE    = 3'd3,
        ST_WRITE_DIR = 3'd4,
        ST_FINISH    = 3'd5
    } trip_state_e;

endpackage

// File: rtl/ow_triplet_capture.sv
// Holds the two read-slot answers of the current step.
module ow_triplet_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic take_id_i,
    input  logic take_cmp_i,
    input  logic level_i,
    output logic id_bit_o,
    output logic cmp_bit_o
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            id_bit_o  <= 1'b0;
            cmp_bit_o <= 1'b0;
        end else begin
            if (take_id_i)
                id_bit_o <= level_i;
            if (take_cmp_i)
                cmp_bit_o <= level_i;
        end
    end

endmodule

// File: rtl/ow_triplet_decide.sv
// Branch decision for one search step; purely combinational.
module ow_triplet_decide
    import ow_triplet_pkg::*;
(
    input  logic             id_bit_i,
    input  logic             cmp_bit_i,
    input  logic             pref_i,
    output logic             restart_o,
    output logic             dir_o,
    output logic [RES_W-1:0] result_o
);

    always_comb begin
        restart_o = id_bit_i & cmp_bit_i;
        if (id_bit_i ^ cmp_bit_i)
            dir_o = id_bit_i;          // only one polarity answered
        else if (restart_o)
            dir_o = 1'b0;              // nobody answered
        else
            dir_o = pref_i;            // both polarities present
        result_o          = '0;
        result_o[RES_ID]  = id_bit_i;
        result_o[RES_CMP] = cmp_bit_i;
        result_o[RES_DIR] = dir_o;
        if (restart_o)
            result_o = RES_RESTART;
    end

endmodule

// File: rtl/ow_search_triplet.sv
module ow_search_triplet
    import ow_triplet_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pref_dir_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic             slot_req_o,
    output logic             slot_wbit_o,
    input  logic             slot_ack_i,
    input  logic             slot_rbit_i
);

    trip_state_e state_q, state_d;

    logic             pref_q;
    logic             dir_q;
    logic [RES_W-1:0] result_q;
    logic             id_bit, cmp_bit;
    logic             dec_restart, dec_dir;
    logic [RES_W-1:0] dec_result;
    logic             accept_start;
    logic             take_id, take_cmp;

    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign take_id      = (state_q == ST_READ_ID)  && slot_ack_i;
    assign take_cmp     = (state_q == ST_READ_CMP) && slot_ack_i;

    ow_triplet_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept_start),
        .take_id_i  (take_id),
        .take_cmp_i (take_cmp),
        .level_i    (slot_rbit_i),
        .id_bit_o   (id_bit),
        .cmp_bit_o  (cmp_bit)
    );

    ow_triplet_decide u_decide (
        .id_bit_i  (id_bit),
        .cmp_bit_i (cmp_bit),
        .pref_i    (pref_q),
        .restart_o (dec_restart),
        .dir_o     (dec_dir),
        .result_o  (dec_result)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i)    state_d = ST_READ_ID;
            ST_READ_ID:   if (slot_ack_i) state_d = ST_READ_CMP;
            ST_READ_CMP:  if (slot_ack_i) state_d = ST_DECIDE;
            ST_DECIDE:    state_d = dec_restart ? ST_FINISH : ST_WRITE_DIR;
            ST_WRITE_DIR: if (slot_ack_i) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pref_q   <= 1'b0;
            dir_q    <= 1'b0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_start)
                pref_q <= pref_dir_i;
            if (state_q == ST_DECIDE) begin
                dir_q    <= dec_dir;
                result_q <= dec_result;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy_o      = 1'b1;
        done_o      = 1'b0;
        slot_req_o  = 1'b0;
        slot_wbit_o = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_READ_ID:   slot_req_o = 1'b1;
            ST_READ_CMP:  slot_req_o = 1'b1;
            ST_DECIDE:    slot_req_o = 1'b0;
            ST_WRITE_DIR: begin
                slot_req_o  = 1'b1;
                slot_wbit_o = dir_q;
            end
            ST_FINISH:    done_o = 1'b1;
            default:      busy_o = 1'b0;
        endcase
    end

    assign result_o = result_q;

endmodule

// File: rtl/ow_search_triplet_chk.sv
module ow_search_triplet_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] result_o,
    input logic       slot_req_o,
    input logic       slot_wbit_o,
    input logic       slot_ack_i
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!slot_req_o && !done_o));

    a_r3_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o[1:0] == 2'b11) ? !result_o[2] :
                    (result_o[1:0] == 2'b01) ?  result_o[2] :
                    (result_o[1:0] == 2'b10) ? !result_o[2] : 1'b1));

    a_r7_wbit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_ack_i) |=> $stable(slot_wbit_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(result_o));

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_ack_i) |=> slot_req_o);

endmodule

bind ow_search_triplet ow_search_triplet_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o),
    .slot_req_o  (slot_req_o),
    .slot_wbit_o (slot_wbit_o),
    .slot_ack_i  (slot_ack_i)
);

// File: tb/tb_ow_search_triplet.sv
`timescale 1ns/1ps
module tb_ow_search_triplet;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       busy_o, done_o, slot_req_o, slot_wbit_o;
    logic [2:0] result_o;
    logic       slot_ack_i = 1'b0;
    logic       slot_rbit_i = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ow_search_triplet dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pref_dir_i  (pref_dir_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o),
        .slot_req_o  (slot_req_o),
        .slot_wbit_o (slot_wbit_o),
        .slot_ack_i  (slot_ack_i),
        .slot_rbit_i (slot_rbit_i)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    // ---------------- slot generator model ----------------
    bit  gen_en = 1'b1;
    int  gen_lat = 1;
    int  gen_cnt = 0;
    bit  rd_q[$];
    bit  wlog[$];

    always @(negedge clk) begin
        if (!gen_en) begin
            gen_cnt = 0;
        end else if (slot_ack_i) begin
            slot_ack_i  = 1'b0;
            slot_rbit_i = 1'b0;
            gen_cnt = 0;
        end else if (slot_req_o) begin
            gen_cnt++;
            if (gen_cnt >= gen_lat) begin
                slot_ack_i  = 1'b1;
                slot_rbit_i = (rd_q.size() > 0) ? rd_q.pop_front() : 1'b0;
                wlog.push_back(slot_wbit_o);
                gen_cnt = 0;
            end
        end else begin
            gen_cnt = 0;
        end
    end

    // ---------------- behavioural reference ----------------
    // phase: 0 idle, 1 first read, 2 second read, 3 choose, 4 write, 5 finished
    int m_phase = 0;
    bit m_pref, m_id, m_cmp, m_dir;
    int m_res = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_res = 0; m_dir = 0;
        end else begin
            if (m_phase == 0) begin
                if (start_i) begin m_phase = 1; m_pref = pref_dir_i; end
            end else if (m_phase == 1) begin
                if (slot_ack_i) begin m_id = slot_rbit_i; m_phase = 2; end
            end else if (m_phase == 2) begin
                if (slot_ack_i) begin m_cmp = slot_rbit_i; m_phase = 3; end
            end else if (m_phase == 3) begin
                if (m_id && m_cmp) begin
                    m_res = 3; m_phase = 5;
                end else begin
                    if (m_id != m_cmp) m_dir = m_id; else m_dir = m_pref;
                    m_res = m_dir * 4 + m_cmp * 2 + m_id;
                    m_phase = 4;
                end
            end else if (m_phase == 4) begin
                if (slot_ack_i) m_phase = 5;
            end else begin
                m_phase = 0;
            end
        end
    end

    bit cmp_en = 1'b0;
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R9 busy", busy_o, (m_phase != 0));
            check("R8 done", done_o, (m_phase == 5));
            check("R12 req", slot_req_o, (m_phase == 1 || m_phase == 2 || m_phase == 4));
            check("R7 wbit", slot_wbit_o, (m_phase == 4) ? m_dir : 1);
            check("R11 result", result_o, m_res);
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse_start(input bit pref);
        @(negedge clk);
        start_i = 1'b1; pref_dir_i = pref;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic run_step(input bit id, input bit cmp, input bit pref,
                            input int exp_res, input int exp_slots,
                            input bit exp_w, input string tag);
        wlog.delete();
        rd_q.push_back(id);
        rd_q.push_back(cmp);
        pulse_start(pref);
        wait_done();
        check({tag, " R3 result"}, result_o, exp_res);
        check({tag, " R4 slot count"}, wlog.size(), exp_slots);
        if (wlog.size() >= 2) begin
            check({tag, " R2 first slot is read"}, wlog[0], 1);
            check({tag, " R2 second slot is read"}, wlog[1], 1);
        end
        if (exp_slots == 3 && wlog.size() == 3)
            check({tag, " R7 direction slot"}, wlog[2], exp_w);
        @(negedge clk);
        check({tag, " R8 done single cycle"}, done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy_o, 0);
        check("R1 req in reset", slot_req_o, 0);
        check("R1 result in reset", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", done_o, 0);
        cmp_en = 1'b1;

        gen_lat = 1;
        run_step(0, 1, 1, 2, 3, 0, "R6 id0");
        run_step(1, 0, 0, 5, 3, 1, "R6 id1");
        run_step(0, 0, 1, 4, 3, 1, "R5 pref1");
        run_step(0, 0, 0, 0, 3, 0, "R5 pref0");
        run_step(1, 1, 1, 3, 2, 0, "R4 restart");

        gen_lat = 4;
        run_step(1, 0, 1, 5, 3, 1, "R6 slow");
        run_step(1, 1, 0, 3, 2, 0, "R4 slow");

        // R12: preferred direction changes after start are ignored
        wlog.delete();
        rd_q.push_back(0); rd_q.push_back(0);
        pulse_start(1);
        pref_dir_i = 1'b0;
        wait_done();
        check("R12 pref sampled at start", result_o, 4);
        check("R12 direction slot", (wlog.size() == 3) ? wlog[2] : 9, 1);

        // R9: a start while busy is ignored
        wlog.delete();
        rd_q.push_back(0); rd_q.push_back(1);
        pulse_start(0);
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (12) @(negedge clk);
        check("R9 no second step", wlog.size(), 3);
        check("R9 idle after ignored start", busy_o, 0);

        // R10: acknowledge while idle has no effect
        gen_en = 1'b0;
        @(negedge clk);
        slot_ack_i = 1'b1; slot_rbit_i = 1'b1;
        @(negedge clk);
        slot_ack_i = 1'b0; slot_rbit_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 busy after stray ack", busy_o, 0);
        check("R10 result after stray ack", result_o, 2);
        check("R10 req after stray ack", slot_req_o, 0);
        gen_en = 1'b1;

        run_step(0, 1, 0, 2, 3, 0, "R11 after stray ack");

        cmp_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule